// File: doc/BRIEF.md
# Frame Medium Access Arbiter

This block picks which of several outgoing virtual channels may put the next data frame on one shared serial link. For each channel it sees a flag saying a whole frame is waiting, a flag saying the receiver at the other end has space for a whole frame, a priority number and a signed bandwidth credit. The credit is computed elsewhere. A schedule of 256 time slots says which channels may send in the current slot.

When the link reports a frame boundary, the block answers one cycle later with a one-hot grant to the winning channel, or with no grant at all. It grants only at boundaries, so a frame already on the wire is never cut short. Among the permitted channels the lowest priority number wins. Credit breaks ties within a priority level, and a channel whose credit has hit the negative floor is shut out.

The slot index either steps on an external start-of-slot pulse or comes from a local cycle counter with a programmable slot length. Software loads schedule entries through a simple write port. If every entry permits every channel, the schedule has no effect on the outcome, but the slot counter keeps running.

Top module: `frame_medium_arbiter`

## Requirements
- R1: A channel can win only if both its frame-ready bit and its far-end-room bit are 1 in the cycle `link_free` is sampled.
- R2: `grant` is registered. It is one-hot or zero, it is nonzero only in the cycle right after a cycle with `link_free` = 1, and it lasts a single cycle. With no eligible channel it stays zero.
- R3: Among eligible channels, the one with the numerically smallest priority value wins, whatever the credits are.
- R4: Among eligible channels with equal priority, the one with the largest credit (two's complement) wins.
- R5: If priority and credit are both equal, the lowest channel index wins.
- R6: A channel whose credit equals the most negative value (8'h80 at the default width) is never granted, even with the best priority.
- R7: Bit i of the schedule entry for the current slot must be 1 for channel i to compete. A write with `tbl_wr_en` = 1 stores `tbl_wr_mask` at `tbl_wr_addr` on that clock edge, and the entry is used from the next cycle.
- R8: With `slot_ext_sel` = 0, `cur_slot` advances by one after every `slot_len` cycles (0 is treated as 1) and wraps from 255 to 0.
- R9: With `slot_ext_sel` = 1, `cur_slot` advances by one on the edge after each cycle in which `slot_start` = 1. Otherwise it holds.
- R10: After reset, `grant` is 0, `cur_slot` is 0 and every schedule entry permits every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_ready | input | N_CH | Bit i: channel i holds a full frame |
| ch_room | input | N_CH | Bit i: far-end buffer of channel i has room for a frame |
| ch_prio | input | N_CH*PRIO_W | Priority per channel, channel i in bits [i*PRIO_W +: PRIO_W]; smaller wins |
| ch_credit | input | N_CH*CRED_W | Signed credit per channel, channel i in bits [i*CRED_W +: CRED_W] |
| link_free | input | 1 | One-cycle pulse: link is at a frame boundary |
| slot_ext_sel | input | 1 | 1: slot steps on `slot_start`; 0: local timer |
| slot_start | input | 1 | External start-of-slot pulse |
| slot_len | input | TICK_W | Slot length in cycles for the local timer |
| tbl_wr_en | input | 1 | Schedule entry write strobe |
| tbl_wr_addr | input | 8 | Slot index to write |
| tbl_wr_mask | input | N_CH | Permitted channels for that slot |
| grant | output | N_CH | One-hot grant pulse |
| cur_slot | output | 8 | Current slot index |

## Verification
The hardest case to reach from the ports is a chosen schedule entry that becomes current at the very moment a boundary arrives. The slot pointer runs freely and the table holds 256 entries. The bench therefore runs mostly in external-pulse mode, steps the slot one pulse at a time, keeps its own copy of the table, and rewrites random entries between arbitrations. This lets random permission masks, floor-valued credits and priority ties meet under a known slot. The local timer is checked separately, over a full 256-slot wrap and with a longer slot length.

// File: rtl/fma_pkg.sv
package fma_pkg;
  localparam int unsigned SLOT_COUNT = 256;
  localparam int unsigned SLOT_W = $clog2(SLOT_COUNT);
  typedef logic [SLOT_W-1:0] slot_idx_t;
endpackage

// File: rtl/fma_slot_clock.sv
module fma_slot_clock
  import fma_pkg::*;
#(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              slot_pulse,
  input  logic [TICK_W-1:0] slot_len,
  output slot_idx_t         slot
);
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] last_tick;
  logic              advance;

  always_comb begin
    last_tick = (slot_len == '0) ? '0 : slot_len - 1'b1;
    advance   = ext_mode ? slot_pulse : (tick_q >= last_tick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot   <= '0;
    end else begin
      if (ext_mode || advance) tick_q <= '0;
      else                     tick_q <= tick_q + 1'b1;
      if (advance) slot <= slot + 1'b1;
    end
  end

  // R8: the slot index only ever moves forward by exactly one
  p_slot_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != $past(slot)) |-> (slot == slot_idx_t'($past(slot) + 1'b1)));

  // R9: in external mode the slot holds without a pulse
  p_ext_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !slot_pulse) |=> $stable(slot));
endmodule

// File: rtl/fma_sched_table.sv
module fma_sched_table
  import fma_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  slot_idx_t       wr_addr,
  input  logic [N_CH-1:0] wr_mask,
  input  slot_idx_t       rd_slot,
  output logic [N_CH-1:0] permit
);
  logic [N_CH-1:0] tbl_q [SLOT_COUNT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SLOT_COUNT); s++) tbl_q[s] <= '1;
    end else if (wr_en) begin
      tbl_q[wr_addr] <= wr_mask;
    end
  end

  assign permit = tbl_q[rd_slot];

  // R7: a write is visible at its address on the following cycle
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tbl_q[$past(wr_addr)] == $past(wr_mask)));
endmodule

// File: rtl/fma_select.sv
module fma_select #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned CRED_W = 8
) (
  input  logic [N_CH-1:0]        elig,
  input  logic [N_CH*PRIO_W-1:0] prio,
  input  logic [N_CH*CRED_W-1:0] credit,
  output logic [N_CH-1:0]        win
);
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic                     found;
  logic [PRIO_W-1:0]        best_p;
  logic signed [CRED_W-1:0] best_c;
  logic [IDX_W-1:0]         best_i;
  logic [PRIO_W-1:0]        p;
  logic signed [CRED_W-1:0] c;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_c = '0;
    best_i = '0;
    p      = '0;
    c      = '0;
    for (int i = 0; i < int'(N_CH); i++) begin
      p = prio[i*PRIO_W +: PRIO_W];
      c = credit[i*CRED_W +: CRED_W];
      // strict comparisons keep the lower index on a full tie
      if (elig[i] && (!found || (p < best_p) || ((p == best_p) && (c > best_c)))) begin
        found  = 1'b1;
        best_p = p;
        best_c = c;
        best_i = IDX_W'(i);
      end
    end
    win = '0;
    if (found) win[best_i] = 1'b1;
  end

  // R1: the winner is always drawn from the eligible set
  always_comb begin
    p_win_in_elig_r1: assert ((win & ~elig) == '0);
  end
endmodule

// File: rtl/frame_medium_arbiter.sv
module frame_medium_arbiter
  import fma_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned CRED_W = 8,
  parameter int unsigned TICK_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        ch_ready,
  input  logic [N_CH-1:0]        ch_room,
  input  logic [N_CH*PRIO_W-1:0] ch_prio,
  input  logic [N_CH*CRED_W-1:0] ch_credit,
  input  logic                   link_free,
  input  logic                   slot_ext_sel,
  input  logic                   slot_start,
  input  logic [TICK_W-1:0]      slot_len,
  input  logic                   tbl_wr_en,
  input  logic [SLOT_W-1:0]      tbl_wr_addr,
  input  logic [N_CH-1:0]        tbl_wr_mask,
  output logic [N_CH-1:0]        grant,
  output logic [SLOT_W-1:0]      cur_slot
);
  localparam logic [CRED_W-1:0] CRED_FLOOR = {1'b1, {(CRED_W-1){1'b0}}};

  logic [N_CH-1:0] permit;
  logic [N_CH-1:0] barred;
  logic [N_CH-1:0] elig;
  logic [N_CH-1:0] win;

  fma_slot_clock #(.TICK_W(TICK_W)) u_clock (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (slot_ext_sel),
    .slot_pulse (slot_start),
    .slot_len   (slot_len),
    .slot       (cur_slot)
  );

  fma_sched_table #(.N_CH(N_CH)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_mask (tbl_wr_mask),
    .rd_slot (cur_slot),
    .permit  (permit)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_bar
    assign barred[g] = (ch_credit[g*CRED_W +: CRED_W] == CRED_FLOOR);
  end

  assign elig = ch_ready & ch_room & permit & ~barred;

  fma_select #(.N_CH(N_CH), .PRIO_W(PRIO_W), .CRED_W(CRED_W)) u_select (
    .elig   (elig),
    .prio   (ch_prio),
    .credit (ch_credit),
    .win    (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) grant <= '0;
    else        grant <= link_free ? win : '0;
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_after_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> $past(link_free));

  p_grant_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & ~$past(ch_ready & ch_room)) == '0));

  p_no_floor_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & $past(barred)) == '0));
endmodule

// File: tb/tb_frame_medium_arbiter.sv
`timescale 1ns/1ps
module tb_frame_medium_arbiter;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int CW = 8;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ch_ready = '0, ch_room = '0;
  logic [N*PW-1:0] ch_prio = '0;
  logic [N*CW-1:0] ch_credit = '0;
  logic link_free = 1'b0, slot_ext_sel = 1'b1, slot_start = 1'b0;
  logic [TW-1:0] slot_len = '0;
  logic tbl_wr_en = 1'b0;
  logic [7:0] tbl_wr_addr = '0;
  logic [N-1:0] tbl_wr_mask = '0;
  logic [N-1:0] grant;
  logic [7:0] cur_slot;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] tbl_m [256];
  int slot_m = 0;
  int pr [N];
  int cr [N];

  always #10 clk = ~clk;

  frame_medium_arbiter #(.N_CH(N), .PRIO_W(PW), .CRED_W(CW), .TICK_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .ch_ready(ch_ready), .ch_room(ch_room),
    .ch_prio(ch_prio), .ch_credit(ch_credit), .link_free(link_free),
    .slot_ext_sel(slot_ext_sel), .slot_start(slot_start), .slot_len(slot_len),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_mask(tbl_wr_mask),
    .grant(grant), .cur_slot(cur_slot));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_ch();
    for (int i = 0; i < N; i++) begin
      ch_prio[i*PW +: PW]   = PW'(pr[i]);
      ch_credit[i*CW +: CW] = CW'(cr[i]);
    end
  endtask

  function automatic logic [N-1:0] model_win();
    int bi = -1;
    for (int i = 0; i < N; i++) begin
      if (ch_ready[i] && ch_room[i] && tbl_m[slot_m][i] && cr[i] != -128) begin
        if (bi < 0 || pr[i] < pr[bi] || (pr[i] == pr[bi] && cr[i] > cr[bi])) bi = i;
      end
    end
    return (bi < 0) ? '0 : N'(1) << bi;
  endfunction

  task automatic arb(input string req);
    logic [N-1:0] exp;
    drive_ch();
    exp = model_win();
    link_free = 1'b1;
    @(negedge clk);
    link_free = 1'b0;
    chk(grant == exp, req, int'(grant), int'(exp));
    @(negedge clk);
    chk(grant == '0, "R2 single-cycle", int'(grant), 0);
  endtask

  task automatic pulse_slot();
    slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    slot_m = (slot_m + 1) % 256;
    chk(int'(cur_slot) == slot_m, "R9 slot step", int'(cur_slot), slot_m);
  endtask

  task automatic wr_tbl(input int a, input logic [N-1:0] m);
    tbl_wr_en = 1'b1; tbl_wr_addr = 8'(a); tbl_wr_mask = m;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    tbl_m[a] = m;
  endtask

  task automatic set_all(input int p, input int c);
    for (int i = 0; i < N; i++) begin pr[i] = p; cr[i] = c; end
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 256; s++) tbl_m[s] = '1;
    set_all(0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(grant == '0, "R10 grant", int'(grant), 0);
    chk(cur_slot == 8'd0, "R10 slot", int'(cur_slot), 0);
    ch_ready = '1; ch_room = '1; set_all(1, 0);
    arb("R10 table all-permit");
    // R2: no boundary, no grant
    drive_ch();
    repeat (3) @(negedge clk);
    chk(grant == '0, "R2 no link_free", int'(grant), 0);
    // R1 eligibility
    ch_ready = 4'b0101; ch_room = 4'b0110;
    arb("R1 ready and room");
    ch_ready = 4'b0011; ch_room = 4'b1100;
    arb("R2 none eligible");
    ch_ready = '1; ch_room = '1;
    // R3 priority
    set_all(1, 100); pr[3] = 0; cr[3] = -100;
    arb("R3 lowest priority number");
    // R4 credit
    set_all(2, 0); cr[0] = -5; cr[1] = 20; cr[2] = 19; cr[3] = -128;
    arb("R4 highest credit");
    // R5 tie
    set_all(1, 7); pr[0] = 2; cr[3] = 6;
    arb("R5 lowest index tie");
    // R6 floor
    set_all(3, -127); pr[0] = 0; cr[0] = -128;
    arb("R6 floor barred");
    ch_ready = 4'b0001;
    arb("R6 floor only");
    ch_ready = '1;
    // R7 schedule mask
    set_all(1, 0);
    wr_tbl(0, 4'b0010);
    arb("R7 mask slot0");
    pulse_slot();
    arb("R7 slot1 untouched");
    wr_tbl(1, 4'b0000);
    arb("R7 empty entry");
    // R8 local timer
    slot_len = 16'd5;
    slot_ext_sel = 1'b0;
    repeat (4) @(negedge clk);
    chk(int'(cur_slot) == slot_m, "R8 hold before len", int'(cur_slot), slot_m);
    @(negedge clk);
    slot_m = (slot_m + 1) % 256;
    chk(int'(cur_slot) == slot_m, "R8 step at len", int'(cur_slot), slot_m);
    repeat (15) @(negedge clk);
    slot_m = (slot_m + 3) % 256;
    chk(int'(cur_slot) == slot_m, "R8 three more slots", int'(cur_slot), slot_m);
    slot_len = 16'd0;
    repeat (5) @(negedge clk);
    slot_ext_sel = 1'b1;
    slot_len = 16'd1;
    @(negedge clk);
    slot_m = int'(cur_slot);
    slot_ext_sel = 1'b0;
    repeat (256) @(negedge clk);
    slot_ext_sel = 1'b1;
    chk(int'(cur_slot) == slot_m, "R8 full wrap", int'(cur_slot), slot_m);
    // R9 hold without pulse
    repeat (6) @(negedge clk);
    chk(int'(cur_slot) == slot_m, "R9 hold", int'(cur_slot), slot_m);
    // random sweep: R1 R3 R4 R5 R6 R7 R9 together
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 3) == 0) wr_tbl($urandom_range(0, 255), N'($urandom_range(0, 15)));
      if ($urandom_range(0, 2) == 0) wr_tbl(slot_m, N'($urandom_range(0, 15)));
      if ($urandom_range(0, 1) == 0) pulse_slot();
      ch_ready = N'($urandom_range(0, 15));
      ch_room  = N'($urandom_range(0, 15));
      for (int i = 0; i < N; i++) begin
        pr[i] = $urandom_range(0, 3);
        case ($urandom_range(0, 3))
          0: cr[i] = -128;
          1: cr[i] = $urandom_range(0, 3) - 1;
          default: cr[i] = $urandom_range(0, 255) - 128;
        endcase
      end
      arb("R1/R3/R4/R5/R6/R7 sweep");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule